// File: doc/BRIEF.md
# I2C Slave Address Acknowledger

This block is the slave end of an I2C link. It samples the bus clock and data lines through a synchroniser and finds START and STOP conditions on the synchronised levels. It shifts in the first byte after each START and compares its upper seven bits with a programmable slave address. It also recognises the all-zero general call address. When the address is accepted, the block pulls SDA low for the acknowledge clock. It then handles the following bytes as a receiver (R/W = 0) or as a transmitter (R/W = 1).

An `ack_en` input selects between two modes. In acknowledgment mode every byte is followed by a ninth clock. In that clock the block answers as receiver or listens as transmitter. In non-acknowledgment mode the block does not count a ninth clock, and the next byte starts on the clock that follows the eighth.

The controller has seven states: `S_IDLE`, `S_ADDR`, `S_ACK_ADDR`, `S_RX_DATA`, `S_ACK_RX`, `S_TX_DATA` and `S_ACK_TX`. The transitions are:

- START from any state goes to `S_ADDR`. STOP from any state goes to `S_IDLE`.
- In `S_ADDR`, the SCL fall that ends the eighth bit is the decision point:
  - with no match it goes to `S_IDLE`;
  - with a match and `ack_en` set it goes to `S_ACK_ADDR`;
  - with a match and `ack_en` clear it goes straight to `S_RX_DATA` or `S_TX_DATA`, chosen by R/W.
- `S_ACK_ADDR` goes to `S_RX_DATA` or `S_TX_DATA` on the SCL fall that ends the ninth clock.
- `S_RX_DATA` goes to `S_ACK_RX` after eight bits when `ack_en` is set. Otherwise it stays in `S_RX_DATA` for the next byte.
- `S_ACK_RX` returns to `S_RX_DATA`.
- `S_TX_DATA` goes to `S_ACK_TX` after eight bits when `ack_en` is set. Otherwise it reloads the transmit byte and stays in `S_TX_DATA`.
- `S_ACK_TX` returns to `S_TX_DATA` when the master acknowledged. It goes to `S_IDLE` when the master did not.

Top module: `i2c_slave_ack`

## Requirements
- R1: After reset, `sda_pull`, `addr_hit`, `gcall_hit` and `byte_done` are 0 and `rx_byte` is 0x00.
- R2: The first byte after a START is taken MSB first. Bits 7:1 are the address and bit 0 is R/W (1 = master reads). When bits 7:1 equal `own_addr`, `addr_hit` goes to 1. In acknowledgment mode, SDA is also pulled low for the ninth clock.
- R3: An address byte of 0x00 sets `gcall_hit` and is acknowledged like R2. The byte 0x01 (zero address with R/W = 1) is not a general call and is not acknowledged.
- R4: When the address matches neither case, both flags stay 0 and SDA stays released for the rest of the transfer. A later START with a matching address is acknowledged again.
- R5: As receiver, each data byte is shifted in MSB first and appears on `rx_byte` after its eighth SCL rise. In acknowledgment mode the byte is acknowledged with SDA low in the ninth clock.
- R6: As transmitter, the block drives `tx_byte` MSB first. It changes its SDA drive only after an SCL fall, a START or a STOP. It releases SDA in the ninth clock.
- R7: A master acknowledge (SDA low in the ninth clock) makes the block load `tx_byte` again and send it. A master no-acknowledge makes it release SDA until the next START.
- R8: In non-acknowledgment mode (`ack_en` = 0) no ninth clock is counted or answered, and the next byte begins with the next SCL clock. Entry into an acknowledge state happens only with `ack_en` set.
- R9: A START or repeated START (SDA falling while SCL is high) restarts the bit count at the address byte. A STOP (SDA rising while SCL is high) clears `addr_hit` and `gcall_hit`.
- R10: `byte_done` is a one-cycle pulse after the eighth SCL rise of the address byte and of every data byte while the block is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Bus clock line level, asynchronous |
| sda_in | input | 1 | Bus data line level, asynchronous |
| own_addr | input | 7 | Programmed 7-bit slave address |
| ack_en | input | 1 | 1 = acknowledgment mode, 0 = no ninth clock |
| tx_byte | input | 8 | Byte to send when the master reads |
| sda_pull | output | 1 | 1 = pull SDA low |
| rx_byte | output | 8 | Last data byte received |
| addr_hit | output | 1 | Own address matched in this transfer |
| gcall_hit | output | 1 | General call received in this transfer |
| byte_done | output | 1 | One-cycle pulse per completed byte |

## Verification
A change on `scl_in` or `sda_in` reaches the bus-event decode after the second synchroniser flop. The state, flags, `rx_byte` and `byte_done` take it on the third clock edge, and `sda_pull` follows the state in the same cycle. The bench changes the master lines on falling clock edges and keeps each half SCL period at eight cycles. It reads the bus and the outputs four cycles into an SCL high phase, or after a whole byte, well after those three edges. `byte_done` pulses are counted on every rising edge, so each one is seen whatever its exact cycle.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_ADDR,
        S_RX_DATA,
        S_ACK_RX,
        S_TX_DATA,
        S_ACK_TX
    } slv_state_t;

    // Level of an undriven bus line
    localparam logic BUS_IDLE = 1'b1;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_ack_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic [1:0] lines;
    logic       scl_now;
    logic       scl_prev;
    logic       sda_prev;

    i2c_line_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_raw, sda_raw}),
        .dout  (lines)
    );

    assign scl_now = lines[1];
    assign sda_lvl = lines[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= BUS_IDLE;
            sda_prev <= BUS_IDLE;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign bus_start = scl_now & scl_prev & sda_prev & ~sda_lvl;
    assign bus_stop  = scl_now & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_slave_ack.sv
module i2c_slave_ack
    import i2c_ack_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              ack_en,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              sda_pull,
    output logic [DATA_W-1:0] rx_byte,
    output logic              addr_hit,
    output logic              gcall_hit,
    output logic              byte_done
);

    localparam int             CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              ev_start;
    logic              ev_stop;

    slv_state_t        state;
    slv_state_t        nxt;

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] tx_sh;
    logic              rw_q;
    logic              got_nack;

    logic              byte_full;
    logic [DATA_W-2:0] rx_addr;
    logic              rx_rw;
    logic              own_match;
    logic              gc_match;
    logic              sel;

    i2c_bus_events #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (ev_start),
        .bus_stop  (ev_stop)
    );

    // Address decode on the completed first byte
    assign byte_full = (bit_cnt == FULL);
    assign rx_addr   = shreg[DATA_W-1:1];
    assign rx_rw     = shreg[0];
    assign own_match = (rx_addr == own_addr);
    assign gc_match  = (rx_addr == '0) && !rx_rw;
    assign sel       = own_match | gc_match;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (ev_start) begin
            nxt = S_ADDR;
        end else if (ev_stop) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    nxt = S_IDLE;
                end
                S_ADDR: begin
                    if (scl_fall && byte_full) begin
                        if (!sel)        nxt = S_IDLE;
                        else if (ack_en) nxt = S_ACK_ADDR;
                        else if (rx_rw)  nxt = S_TX_DATA;
                        else             nxt = S_RX_DATA;
                    end
                end
                S_ACK_ADDR: begin
                    if (scl_fall) nxt = rw_q ? S_TX_DATA : S_RX_DATA;
                end
                S_RX_DATA: begin
                    if (scl_fall && byte_full && ack_en) nxt = S_ACK_RX;
                end
                S_ACK_RX: begin
                    if (scl_fall) nxt = S_RX_DATA;
                end
                S_TX_DATA: begin
                    if (scl_fall && byte_full && ack_en) nxt = S_ACK_TX;
                end
                S_ACK_TX: begin
                    if (scl_fall) nxt = got_nack ? S_IDLE : S_TX_DATA;
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        sda_pull = 1'b0;
        unique case (state)
            S_ACK_ADDR, S_ACK_RX: sda_pull = 1'b1;
            S_TX_DATA:            sda_pull = ~tx_sh[DATA_W-1];
            default:              sda_pull = 1'b0;
        endcase
    end

    // Datapath: bit counter, shifters, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            tx_sh     <= '1;
            rw_q      <= 1'b0;
            got_nack  <= 1'b0;
            rx_byte   <= '0;
            addr_hit  <= 1'b0;
            gcall_hit <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (ev_start || ev_stop) begin
                bit_cnt   <= '0;
                addr_hit  <= 1'b0;
                gcall_hit <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_RX_DATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg   <= {shreg[DATA_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST) begin
                                byte_done <= 1'b1;
                                if (state == S_RX_DATA) begin
                                    rx_byte <= {shreg[DATA_W-2:0], sda_lvl};
                                end
                            end
                        end
                        if (scl_fall && byte_full) begin
                            bit_cnt <= '0;
                            if (state == S_ADDR) begin
                                addr_hit  <= own_match;
                                gcall_hit <= gc_match;
                                rw_q      <= rx_rw;
                                if (sel && !ack_en && rx_rw) tx_sh <= tx_byte;
                            end
                        end
                    end
                    S_ACK_ADDR: begin
                        if (scl_fall && rw_q) tx_sh <= tx_byte;
                    end
                    S_TX_DATA: begin
                        if (scl_rise && !byte_full) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST) byte_done <= 1'b1;
                        end
                        if (scl_fall) begin
                            if (byte_full) begin
                                bit_cnt <= '0;
                                if (!ack_en) tx_sh <= tx_byte;
                            end else begin
                                tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
                            end
                        end
                    end
                    S_ACK_TX: begin
                        if (scl_rise) got_nack <= sda_lvl;
                        if (scl_fall && !got_nack) tx_sh <= tx_byte;
                    end
                    default: begin
                        bit_cnt <= bit_cnt;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_ack_checker.sv
module i2c_ack_checker
    import i2c_ack_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_fall,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             sda_pull,
    input  logic             addr_hit,
    input  logic             gcall_hit,
    input  logic             byte_done,
    input  logic             ack_en,
    input  slv_state_t       state,
    input  logic [CNT_W-1:0] bit_cnt
);

    logic in_ack;
    assign in_ack = (state == S_ACK_ADDR) || (state == S_ACK_RX) || (state == S_ACK_TX);

    a_r6_pull_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall || ev_start || ev_stop));

    a_r4_pull_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (addr_hit || gcall_hit));

    a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (!addr_hit && !gcall_hit));

    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (bit_cnt == '0 && state == S_ADDR));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    a_r8_ack_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && !$past(in_ack)) |-> $past(ack_en));

endmodule

bind i2c_slave_ack i2c_ack_checker #(
    .CNT_W (CNT_W)
) u_ack_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .sda_pull  (sda_pull),
    .addr_hit  (addr_hit),
    .gcall_hit (gcall_hit),
    .byte_done (byte_done),
    .ack_en    (ack_en),
    .state     (state),
    .bit_cnt   (bit_cnt)
);

// File: tb/i2c_slave_ack_bench.sv
module i2c_slave_ack_bench;

    localparam int H  = 8;
    localparam int NV = 7;
    // {addr[6:0], rw, own[6:0], ack_en, data[7:0], exp_ack, exp_hit, exp_gc}
    localparam logic [26:0] VEC [NV] = '{
        {7'h52, 1'b0, 7'h52, 1'b1, 8'hA5, 3'b110},
        {7'h00, 1'b0, 7'h52, 1'b1, 8'h3C, 3'b101},
        {7'h53, 1'b0, 7'h52, 1'b1, 8'h00, 3'b000},
        {7'h2A, 1'b1, 7'h2A, 1'b1, 8'hC3, 3'b110},
        {7'h7F, 1'b0, 7'h7F, 1'b0, 8'h81, 3'b010},
        {7'h00, 1'b1, 7'h11, 1'b1, 8'h00, 3'b000},
        {7'h15, 1'b1, 7'h15, 1'b0, 8'hB5, 3'b010}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [6:0] own = 7'h00;
    logic       ack_en = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       sda_pull;
    logic [7:0] rx_byte;
    logic       addr_hit;
    logic       gcall_hit;
    logic       byte_done;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_slave_ack u_i2c_slave_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .own_addr  (own),
        .ack_en    (ack_en),
        .tx_byte   (tx_byte),
        .sda_pull  (sda_pull),
        .rx_byte   (rx_byte),
        .addr_hit  (addr_hit),
        .gcall_hit (gcall_hit),
        .byte_done (byte_done)
    );

    always @(posedge clk) if (rst_n && byte_done) done_cnt <= done_cnt + 1;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        idle(2); sda_m = 1'b1; idle(H);
        scl_m = 1'b1; idle(H);
        sda_m = 1'b0; idle(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        idle(2); sda_m = 1'b0; idle(H);
        scl_m = 1'b1; idle(H);
        sda_m = 1'b1; idle(H);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        idle(2); sda_m = b; idle(H - 2);
        scl_m = 1'b1; idle(H / 2);
        seen = sda_bus; idle(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        logic dummy;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], dummy);
    endtask

    task automatic read_byte(output logic [7:0] b);
        logic bv;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, bv);
            b[i] = bv;
        end
    endtask

    initial begin
        logic [6:0] va, vo;
        logic       vrw, vae, s, vsel;
        logic [7:0] vd, got;
        logic [2:0] vexp;
        int         base;

        idle(4);
        check("R1 sda_pull after reset", 8'(sda_pull), 8'h0);
        check("R1 addr_hit after reset", 8'(addr_hit), 8'h0);
        check("R1 gcall_hit after reset", 8'(gcall_hit), 8'h0);
        check("R1 rx_byte after reset", rx_byte, 8'h00);
        check("R1 byte_done after reset", 8'(byte_done), 8'h0);
        rst_n = 1'b1;
        idle(4);

        for (int v = 0; v < NV; v++) begin
            {va, vrw, vo, vae, vd, vexp} = VEC[v];
            own = vo; ack_en = vae; tx_byte = vd;
            vsel = vexp[1] | vexp[0];
            base = done_cnt;
            bus_start();
            write_byte({va, vrw});
            if (vae) begin
                clk_bit(1'b1, s);
                check($sformatf("R2 R3 R4 address ack v%0d", v), 8'(s), 8'(!vexp[2]));
            end
            if (vsel && !vrw) begin
                write_byte(vd);
                check($sformatf("R5 R8 rx_byte v%0d", v), rx_byte, vd);
                if (vae) begin
                    clk_bit(1'b1, s);
                    check($sformatf("R5 data ack v%0d", v), 8'(s), 8'h0);
                end
            end else begin
                read_byte(got);
                check($sformatf("R6 R4 bus byte v%0d", v), got, vsel ? vd : 8'hFF);
                if (vae) begin
                    clk_bit(1'b1, s);
                    check($sformatf("R6 released in ack v%0d", v), 8'(s), 8'h1);
                end
            end
            check($sformatf("R2 addr_hit v%0d", v), 8'(addr_hit), 8'(vexp[1]));
            check($sformatf("R3 gcall_hit v%0d", v), 8'(gcall_hit), 8'(vexp[0]));
            check($sformatf("R10 byte_done count v%0d", v), 8'(done_cnt - base), vsel ? 8'd2 : 8'd1);
            bus_stop();
            check($sformatf("R9 flags cleared by stop v%0d", v), 8'({addr_hit, gcall_hit}), 8'h0);
        end

        // R7: master ACK reloads, NACK releases until START
        own = 7'h2A; ack_en = 1'b1; tx_byte = 8'h96;
        bus_start();
        write_byte({7'h2A, 1'b1});
        clk_bit(1'b1, s);
        read_byte(got);
        check("R7 first transmitted byte", got, 8'h96);
        tx_byte = 8'h69;
        clk_bit(1'b0, s);
        read_byte(got);
        check("R7 byte after master ack", got, 8'h69);
        clk_bit(1'b1, s);
        read_byte(got);
        check("R7 released after master nack", got, 8'hFF);
        bus_stop();

        // R9: repeated START in mid byte restarts the address count
        own = 7'h52;
        bus_start();
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
        bus_start();
        write_byte({7'h52, 1'b0});
        clk_bit(1'b1, s);
        check("R9 ack after repeated start", 8'(s), 8'h0);
        check("R9 addr_hit after repeated start", 8'(addr_hit), 8'h1);
        bus_stop();

        // R4: mismatch stays silent, next START selects again
        bus_start();
        write_byte({7'h33, 1'b0});
        clk_bit(1'b1, s);
        check("R4 mismatch not acked", 8'(s), 8'h1);
        write_byte({7'h52, 1'b0});
        clk_bit(1'b1, s);
        check("R4 silent until next start", 8'(s), 8'h1);
        bus_start();
        write_byte({7'h52, 1'b0});
        clk_bit(1'b1, s);
        check("R4 acked after new start", 8'(s), 8'h0);
        bus_stop();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, all requirements unfinished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule